// File: doc/BRIEF.md
# External Bus Port Controller

The controller sits between a small CPU core and the shared port pins of its chip. For every program fetch or data access it decides whether the access stays inside the chip or goes to external memory. For an external access it runs a fixed-length bus cycle. The address comes out on three ports. Port 0 carries the data. One of three dedicated strobe pins pulses low for the access.

Program space and data space use different internal limits. A mode pin, sampled when any reset cause ends, decides whether program space has an internal part. When that pin is low, the same reset also gives ports 0, 1, 2 and 4 and the program-strobe pin their bus roles. The read and write strobe pins are left under general-purpose control until software enables them.

Each pin group has its own secondary-function enable bit. A pin whose bit is clear follows its general-purpose output and output-enable values, even while a bus cycle runs. A port whose bit is set drives only while an external access is active. At all other times it floats with its pull-up on.

Top module: `ext_bus_port_ctrl`

## Requirements
- R1: With the sampled mode pin high, a fetch (`type_i`=0) at an address below 0x20000 is internal, and a fetch at 0x20000 or above is external.
- R2: With the sampled mode pin low, every fetch is external, including one at address 0.
- R3: A read (`type_i`=1) or write (`type_i`=2) is internal below 0x02000 and external at 0x02000 or above, whatever the mode pin.
- R4: During an external access, port 1 drives address bits [7:0] and port 2 drives bits [15:8], each only when its enable bit is set. The low nibble of port 4 drives bits [19:16]. The high nibble of port 4 always stays general-purpose.
- R5: During an external write, port 0 drives the write data for the whole access. During a fetch or read, port 0 does not drive. The value on `pad_i` in the last strobe cycle appears on `rdata_o` in the final cycle of the access.
- R6: Strobe pin 0 (program), pin 1 (read) and pin 2 (write) are active low. When its enable bit is set, a pin drives high except in the strobe cycles of a matching external access. The strobe cycles are cycles 2 to N-1 of an N-cycle access.
- R7: An accepted request starts its cycles at the next clock. An external access is `busy_o` for exactly `ACC_CYCLES` cycles, with `done_o` in the last of them. Requests are ignored while `busy_o` is high.
- R8: A pin whose enable bit is clear takes its value and output enable from the general-purpose inputs and has its pull-up off, even during an external access.
- R9: The enable bits are, from bit 0 upward: port 0, port 1, port 2, port 4, program strobe, read strobe and write strobe. At the first clock after the reset pin releases, or at any clock where a break, watchdog-overflow or trap cause is high, the enables load 0x1F if `mode_i` is low and 0x00 if it is high. The mode level is sampled at the same time.
- R10: A port whose enable bit is set, with no external access in progress, does not drive and has its pull-up on.
- R11: A write through `sfe_we_i` replaces the enable bits, so software can return an auto-enabled port, such as port 4, to general-purpose use.
- R12: An internal access shows `busy_o` and `done_o` for one cycle, keeps `ext_o` low and leaves every pin unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset pin |
| rst_brk_i | input | 1 | Break-instruction reset cause |
| rst_wdt_i | input | 1 | Watchdog-overflow reset cause |
| rst_trap_i | input | 1 | Opcode-trap reset cause |
| mode_i | input | 1 | External-access mode pin, sampled at reset |
| req_i | input | 1 | Access request |
| type_i | input | 2 | 0 fetch, 1 read, 2 write |
| addr_i | input | 20 | Access address |
| wdata_i | input | 8 | Write data |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | Last cycle of an access |
| ext_o | output | 1 | External access in progress |
| rdata_o | output | 8 | Data captured from port 0 |
| sfe_we_i | input | 1 | Enable-register write strobe |
| sfe_wdata_i | input | 7 | Enable-register write value |
| sfe_o | output | 7 | Enable-register contents |
| gpio_out_i | input | 4x8 | General-purpose values, ports 0, 1, 2, 4 |
| gpio_oe_i | input | 4x8 | General-purpose output enables, ports 0, 1, 2, 4 |
| pad_i | input | 8 | Port 0 pin input |
| pad_o | output | 4x8 | Pin values, ports 0, 1, 2, 4 |
| pad_oe_o | output | 4x8 | Pin output enables |
| pad_pu_o | output | 4 | Per-port pull-up enable |
| sgpio_out_i | input | 3 | General-purpose values of strobe pins |
| sgpio_oe_i | input | 3 | General-purpose output enables of strobe pins |
| strb_o | output | 3 | Strobe pin values |
| strb_oe_o | output | 3 | Strobe pin output enables |

## Verification
The bench aims at the edges of the address limits: 0x1FFFF against 0x20000 for fetches and 0x01FFF against 0x02000 for data. A design with an off-by-one limit, or one that applies the mode pin to data space, would flag the wrong access as external. The bench also runs a data access before the read and write strobe pins are enabled. There, a design that forced those pins at reset would pulse a strobe. A port returned to general-purpose use by software must keep its general-purpose values while address cycles run. A design that latched the wrong `pad_i` cycle, or let the strobe overlap the address setup or the write-data hold cycle, fails the per-cycle pin comparison. All three reset causes and the mode-high reset are covered, and they expose enables loaded with the wrong value.

// File: rtl/ebp_pkg.sv
package ebp_pkg;
  localparam int ADDR_W  = 20;
  localparam int PORT_W  = 8;
  localparam int N_BPORT = 4;
  localparam int N_STRB  = 3;
  localparam int SFE_W   = N_BPORT + N_STRB;
  localparam logic [SFE_W-1:0] SFE_AUTO = 7'h1F;
  localparam logic [ADDR_W-1:0] PROG_INT_END = 20'h20000;
  localparam logic [ADDR_W-1:0] DATA_INT_END = 20'h02000;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_INT  = 2'd1,
    ST_EXT  = 2'd2
  } st_e;
endpackage

// File: rtl/ebp_decode.sv
module ebp_decode
  import ebp_pkg::*;
(
  input  logic [1:0]        type_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              mode_q_i,
  output logic              ext_o
);
  always_comb begin
    if (type_i == ACC_FETCH) ext_o = !mode_q_i || (addr_i >= PROG_INT_END);
    else                     ext_o = addr_i >= DATA_INT_END;
  end
endmodule

// File: rtl/ebp_seq.sv
module ebp_seq
  import ebp_pkg::*;
#(
  parameter int ACC_CYCLES = 4,
  localparam int CW = $clog2(ACC_CYCLES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_rst_i,
  input  logic              req_i,
  input  logic              ext_i,
  input  logic [1:0]        type_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PORT_W-1:0] wdata_i,
  input  logic [PORT_W-1:0] pad0_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              in_ext_o,
  output logic              strb_phase_o,
  output logic [1:0]        type_q_o,
  output logic [ADDR_W-1:0] addr_q_o,
  output logic [PORT_W-1:0] wdata_q_o,
  output logic [PORT_W-1:0] rdata_o
);
  localparam logic [CW-1:0] LAST = CW'(ACC_CYCLES - 1);
  localparam logic [CW-1:0] LSTB = CW'(ACC_CYCLES - 2);

  st_e st_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      type_q_o  <= '0;
      addr_q_o  <= '0;
      wdata_q_o <= '0;
      rdata_o   <= '0;
    end else if (sync_rst_i) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      if (st_q == ST_EXT && cnt_q == LSTB && type_q_o != ACC_WRITE) rdata_o <= pad0_i;
      unique case (st_q)
        ST_IDLE: if (req_i) begin
          st_q      <= ext_i ? ST_EXT : ST_INT;
          cnt_q     <= '0;
          type_q_o  <= type_i;
          addr_q_o  <= addr_i;
          wdata_q_o <= wdata_i;
        end
        ST_INT: st_q <= ST_IDLE;
        ST_EXT: begin
          if (cnt_q == LAST) st_q <= ST_IDLE;
          cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o       = st_q != ST_IDLE;
  assign in_ext_o     = st_q == ST_EXT;
  assign done_o       = (st_q == ST_INT) || (in_ext_o && cnt_q == LAST);
  assign strb_phase_o = in_ext_o && cnt_q != '0 && cnt_q != LAST;

  AST_DONE_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_STRB_NOT_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_ext_o) |-> !strb_phase_o); // R6
endmodule

// File: rtl/ebp_pinmux.sv
module ebp_pinmux
  import ebp_pkg::*;
(
  input  logic [N_BPORT-1:0]             sfe_bus_i,
  input  logic [N_STRB-1:0]              sfe_strb_i,
  input  logic                           ext_act_i,
  input  logic [N_BPORT-1:0][PORT_W-1:0] bus_val_i,
  input  logic [N_BPORT-1:0][PORT_W-1:0] bus_mask_i,
  input  logic [N_BPORT-1:0][PORT_W-1:0] bus_drv_i,
  input  logic [N_STRB-1:0]              strb_act_i,
  input  logic [N_BPORT-1:0][PORT_W-1:0] gpio_out_i,
  input  logic [N_BPORT-1:0][PORT_W-1:0] gpio_oe_i,
  input  logic [N_STRB-1:0]              sgpio_out_i,
  input  logic [N_STRB-1:0]              sgpio_oe_i,
  output logic [N_BPORT-1:0][PORT_W-1:0] pad_o,
  output logic [N_BPORT-1:0][PORT_W-1:0] pad_oe_o,
  output logic [N_BPORT-1:0]             pad_pu_o,
  output logic [N_STRB-1:0]              strb_o,
  output logic [N_STRB-1:0]              strb_oe_o
);
  for (genvar p = 0; p < N_BPORT; p++) begin : g_port
    for (genvar b = 0; b < PORT_W; b++) begin : g_bit
      logic role;
      assign role = sfe_bus_i[p] && bus_mask_i[p][b];
      assign pad_o[p][b]    = role ? (ext_act_i && bus_val_i[p][b]) : gpio_out_i[p][b];
      assign pad_oe_o[p][b] = role ? (ext_act_i && bus_drv_i[p][b]) : gpio_oe_i[p][b];
    end
    // idle bus port floats pulled up
    assign pad_pu_o[p] = sfe_bus_i[p] && !ext_act_i;
  end

  for (genvar s = 0; s < N_STRB; s++) begin : g_strb
    assign strb_o[s]    = sfe_strb_i[s] ? !strb_act_i[s] : sgpio_out_i[s];
    assign strb_oe_o[s] = sfe_strb_i[s] || sgpio_oe_i[s];
  end
endmodule

// File: rtl/ext_bus_port_ctrl.sv
module ext_bus_port_ctrl
  import ebp_pkg::*;
#(
  parameter int ACC_CYCLES = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           rst_brk_i,
  input  logic                           rst_wdt_i,
  input  logic                           rst_trap_i,
  input  logic                           mode_i,
  input  logic                           req_i,
  input  logic [1:0]                     type_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [PORT_W-1:0]              wdata_i,
  output logic                           busy_o,
  output logic                           done_o,
  output logic                           ext_o,
  output logic [PORT_W-1:0]              rdata_o,
  input  logic                           sfe_we_i,
  input  logic [SFE_W-1:0]               sfe_wdata_i,
  output logic [SFE_W-1:0]               sfe_o,
  input  logic [N_BPORT-1:0][PORT_W-1:0] gpio_out_i,
  input  logic [N_BPORT-1:0][PORT_W-1:0] gpio_oe_i,
  input  logic [PORT_W-1:0]              pad_i,
  output logic [N_BPORT-1:0][PORT_W-1:0] pad_o,
  output logic [N_BPORT-1:0][PORT_W-1:0] pad_oe_o,
  output logic [N_BPORT-1:0]             pad_pu_o,
  input  logic [N_STRB-1:0]              sgpio_out_i,
  input  logic [N_STRB-1:0]              sgpio_oe_i,
  output logic [N_STRB-1:0]              strb_o,
  output logic [N_STRB-1:0]              strb_oe_o
);
  logic [SFE_W-1:0] sfe_q;
  logic mode_q, pend_q, sync_rst, dec_ext, strb_phase;
  logic [1:0] type_q;
  logic [ADDR_W-1:0] addr_q;
  logic [PORT_W-1:0] wdata_q;
  logic [N_BPORT-1:0][PORT_W-1:0] bus_val, bus_mask, bus_drv;
  logic [N_STRB-1:0] strb_act;

  assign sync_rst = pend_q || rst_brk_i || rst_wdt_i || rst_trap_i;

  // enables and mode load on the first clock after any reset cause
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sfe_q  <= '0;
      mode_q <= 1'b1;
      pend_q <= 1'b1;
    end else if (sync_rst) begin
      sfe_q  <= mode_i ? '0 : SFE_AUTO;
      mode_q <= mode_i;
      pend_q <= 1'b0;
    end else if (sfe_we_i) begin
      sfe_q <= sfe_wdata_i;
    end
  end
  assign sfe_o = sfe_q;

  ebp_decode u_dec (
    .type_i(type_i), .addr_i(addr_i), .mode_q_i(mode_q), .ext_o(dec_ext)
  );

  ebp_seq #(.ACC_CYCLES(ACC_CYCLES)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .sync_rst_i(sync_rst), .req_i(req_i),
    .ext_i(dec_ext), .type_i(type_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .pad0_i(pad_i), .busy_o(busy_o), .done_o(done_o), .in_ext_o(ext_o),
    .strb_phase_o(strb_phase), .type_q_o(type_q), .addr_q_o(addr_q),
    .wdata_q_o(wdata_q), .rdata_o(rdata_o)
  );

  always_comb begin
    bus_val[0]  = wdata_q;
    bus_mask[0] = '1;
    bus_drv[0]  = (type_q == ACC_WRITE) ? '1 : '0;
    bus_val[1]  = addr_q[7:0];
    bus_mask[1] = '1;
    bus_drv[1]  = '1;
    bus_val[2]  = addr_q[15:8];
    bus_mask[2] = '1;
    bus_drv[2]  = '1;
    bus_val[3]  = {{(2*PORT_W-ADDR_W+8){1'b0}}, addr_q[ADDR_W-1:16]};
    bus_mask[3] = {{(2*PORT_W-ADDR_W+8){1'b0}}, {(ADDR_W-16){1'b1}}};
    bus_drv[3]  = bus_mask[3];
  end

  for (genvar s = 0; s < N_STRB; s++) begin : g_sact
    assign strb_act[s] = strb_phase && (type_q == 2'(s));
  end

  ebp_pinmux u_mux (
    .sfe_bus_i(sfe_q[N_BPORT-1:0]), .sfe_strb_i(sfe_q[SFE_W-1:N_BPORT]),
    .ext_act_i(ext_o), .bus_val_i(bus_val), .bus_mask_i(bus_mask),
    .bus_drv_i(bus_drv), .strb_act_i(strb_act), .gpio_out_i(gpio_out_i),
    .gpio_oe_i(gpio_oe_i), .sgpio_out_i(sgpio_out_i), .sgpio_oe_i(sgpio_oe_i),
    .pad_o(pad_o), .pad_oe_o(pad_oe_o), .pad_pu_o(pad_pu_o),
    .strb_o(strb_o), .strb_oe_o(strb_oe_o)
  );

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~strb_o & sfe_q[SFE_W-1:N_BPORT])); // R6
  AST_STRB_NEEDS_EXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~strb_o & sfe_q[SFE_W-1:N_BPORT]) != '0) |-> ext_o); // R12
  AST_IDLE_FLOAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sfe_q[0] && !ext_o) |-> (pad_oe_o[0] == '0 && pad_pu_o[0])); // R10
  AST_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_o && $past(ext_o) && !$past(done_o) && sfe_q[1] && $stable(sfe_q))
      |-> $stable(pad_o[1])); // R4
  AST_WR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sfe_q[0] && sfe_q[6] && $past(sfe_q[0] && sfe_q[6]) && $rose(strb_o[2]) && ext_o)
      |-> (pad_oe_o[0] == '1)); // R5
endmodule

// File: tb/ext_bus_port_ctrl_bench.sv
module ext_bus_port_ctrl_bench;
  localparam int ACC = 4;
  logic clk = 0, rst_n = 0;
  logic brk = 0, wdt = 0, trap = 0, mode = 0, req = 0, sfe_we = 0;
  logic [1:0] typ = 0;
  logic [19:0] addr = 0;
  logic [7:0] wdata = 0, pad_in = 0, rdata;
  logic [6:0] sfe_wd = 0, sfe;
  logic [3:0][7:0] gout, goe, pad, pad_oe;
  logic [3:0] pu;
  logic [2:0] sgout = 3'b010, sgoe = 3'b001, strb, strb_oe;
  logic busy, done, ext;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  ext_bus_port_ctrl #(.ACC_CYCLES(ACC)) u_ext_bus_port_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .rst_brk_i(brk), .rst_wdt_i(wdt), .rst_trap_i(trap),
    .mode_i(mode), .req_i(req), .type_i(typ), .addr_i(addr), .wdata_i(wdata),
    .busy_o(busy), .done_o(done), .ext_o(ext), .rdata_o(rdata),
    .sfe_we_i(sfe_we), .sfe_wdata_i(sfe_wd), .sfe_o(sfe),
    .gpio_out_i(gout), .gpio_oe_i(goe), .pad_i(pad_in), .pad_o(pad),
    .pad_oe_o(pad_oe), .pad_pu_o(pu), .sgpio_out_i(sgout), .sgpio_oe_i(sgoe),
    .strb_o(strb), .strb_oe_o(strb_oe)
  );

  // reference model
  int ph;
  bit pend, m_mode;
  logic [6:0] m_sfe;
  logic [1:0] m_typ;
  logic [19:0] m_addr;
  logic [7:0] m_wd, m_rd;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = -1; pend = 1; m_sfe = 0; m_rd = 0; m_mode = 1;
      m_typ = 0; m_addr = 0; m_wd = 0;
    end else if (pend || brk || wdt || trap) begin
      m_mode = mode; m_sfe = mode ? 7'h00 : 7'h1F; pend = 0; ph = -1;
    end else begin
      bit e;
      if (ph == ACC-2 && m_typ != 2) m_rd = pad_in;
      if (ph == -1 && req) begin
        e = (typ == 0) ? (!m_mode || addr >= 20'h20000) : (addr >= 20'h02000);
        m_typ = typ; m_addr = addr; m_wd = wdata;
        ph = e ? 0 : -2;
      end else if (ph == -2) ph = -1;
      else if (ph >= 0) ph = (ph == ACC-1) ? -1 : ph + 1;
      if (sfe_we) m_sfe = sfe_wd;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", rq, what, act, exp, $time);
    end
  endtask

  task automatic check(input string ext_tag);
    bit ie;
    logic [7:0] eo, ev;
    logic [2:0] so, soe;
    ie = ph >= 0;
    for (int p = 0; p < 4; p++) begin
      for (int b = 0; b < 8; b++) begin
        bit role;
        logic v;
        role = m_sfe[p] && (p != 3 || b < 4);
        v = (p == 0) ? m_wd[b] : m_addr[8*(p-1)+b];
        eo[b] = role ? (ie && (p != 0 || m_typ == 2)) : goe[p][b];
        ev[b] = role ? v : gout[p][b];
      end
      chk(pad_oe[p] === eo, !m_sfe[p] ? "R8" : (p == 0 ? "R5" : "R4"),
          $sformatf("oe port%0d", p), pad_oe[p], eo);
      chk((pad[p] & eo) === (ev & eo), !m_sfe[p] ? "R8" : (p == 0 ? "R5" : "R4"),
          $sformatf("val port%0d", p), pad[p], ev);
      chk(pu[p] === (m_sfe[p] && !ie), m_sfe[p] ? "R10" : "R8",
          $sformatf("pu port%0d", p), pu[p], m_sfe[p] && !ie);
    end
    for (int s = 0; s < 3; s++) begin
      so[s]  = m_sfe[4+s] ? !(ph >= 1 && ph <= ACC-2 && m_typ == 2'(s)) : sgout[s];
      soe[s] = m_sfe[4+s] ? 1'b1 : sgoe[s];
    end
    chk(strb === so && strb_oe === soe, "R6", "strobes", {strb_oe, strb}, {soe, so});
    chk(busy === (ph != -1), "R7", "busy", busy, ph != -1);
    chk(done === (ph == -2 || ph == ACC-1), "R7", "done", done, ph == -2 || ph == ACC-1);
    chk(ext === ie, ext_tag, "ext", ext, ie);
    chk(sfe === m_sfe, "R9", "sfe", sfe, m_sfe);
    if (ph == ACC-1 && m_typ != 2) chk(rdata === m_rd, "R5", "rdata", rdata, m_rd);
  endtask

  task automatic tick(input string tag);
    @(posedge clk); #1; check(tag);
  endtask

  task automatic access(input logic [1:0] t, input logic [19:0] a,
                        input logic [7:0] wd, input logic [7:0] pi, input string tag);
    typ = t; addr = a; wdata = wd; pad_in = pi; req = 1;
    tick(tag);
    req = 0; addr = ~a;
    repeat (ACC + 1) tick(tag);
  endtask

  task automatic set_sfe(input logic [6:0] v, input string tag);
    sfe_wd = v; sfe_we = 1; tick(tag); sfe_we = 0; tick(tag);
  endtask

  initial begin
    #800000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int p = 0; p < 4; p++) begin
      gout[p] = 8'h5A ^ 8'(p * 17);
      goe[p]  = 8'hC3 ^ 8'(p);
    end
    mode = 0; rst_n = 0;
    #9; rst_n = 1;
    tick("R9"); tick("R9");   // mode low: enables 0x1F, ports float pulled up (R10)
    access(0, 20'h00010, 0, 8'hA5, "R2");    // fetch at low address external when mode low
    access(0, 20'h00000, 0, 8'h11, "R2");
    access(1, 20'h01FFF, 0, 8'h22, "R3");    // internal data, also R12
    access(1, 20'h02000, 0, 8'h33, "R3");    // external, read strobe still general-purpose
    access(2, 20'h02001, 8'h44, 0, "R3");
    set_sfe(7'h7F, "R11");
    access(2, 20'hABCDE, 8'h3C, 0, "R5");
    access(1, 20'h12345, 0, 8'h5A, "R5");
    access(0, 20'hFFFFF, 0, 8'hC6, "R4");
    // request held high through an access: extra requests ignored (R7)
    typ = 1; addr = 20'h0F0F0; req = 1;
    repeat (2 * ACC + 3) tick("R7");
    req = 0; tick("R7");
    set_sfe(7'h77, "R11");                   // port 4 back to general-purpose
    access(0, 20'hF00AB, 0, 8'h77, "R11");
    sgout = 3'b101; sgoe = 3'b110;
    set_sfe(7'h0F, "R8");
    access(2, 20'h4567A, 8'h99, 0, "R8");
    // synchronous causes with mode low
    brk = 1; tick("R9"); brk = 0; tick("R9");
    set_sfe(7'h00, "R11");
    wdt = 1; tick("R9"); wdt = 0; tick("R9");
    trap = 1; mode = 1; tick("R9"); trap = 0; tick("R9");
    // pin reset with mode high
    mode = 1; #1; rst_n = 0; #5; rst_n = 1;
    tick("R9"); tick("R9");
    access(0, 20'h1FFFF, 0, 8'h01, "R1");    // internal, R12
    access(0, 20'h20000, 0, 8'h02, "R1");    // external, every pin general-purpose (R8)
    access(1, 20'h01FFF, 0, 8'h03, "R3");
    access(1, 20'h02000, 0, 8'h04, "R3");
    set_sfe(7'h1F, "R11");
    access(0, 20'h00100, 0, 8'h05, "R12");   // still internal with mode high
    access(0, 20'h3ABCD, 0, 8'hE7, "R1");
    mode = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule